// File: doc/BRIEF.md
# SPI Flash Command Engine

This block is a byte-addressed SPI master that performs one flash transaction per start. Software places an opcode in its own register, a transmit count and a receive count in a count register, and payload bytes in an eight-entry byte store reached through a single data port. It then sets the start bit.

The engine then lowers chip select and shifts out the opcode, followed by the payload. It clocks in the requested number of response bytes and writes them back into the same store, just after the payload. Chip select is then released. Software clears the data-port pointer, steps past the payload bytes and reads the response.

The register access port uses a valid/ready handshake. `acc_ready` is always high, so every cycle with `acc_valid` high is exactly one access and no access is ever held off. Read data is combinational from `acc_addr`, and a data-port read advances the pointer at the clock edge that ends the access. The SPI pins are plain.

Top module: `spi_cmd_engine`

## Requirements
- R1: After reset, `spi_cs_n` is 1, `spi_sclk` is 0, `acc_ready` is 1, and every register (opcode, count, control, status, data at pointer 0, pointer) reads 0.
- R2: The register map is fixed:
  - offset 0x0 is the opcode.
  - offset 0x1 is the count: bits 3:0 are the transmit count and bits 7:4 are the receive field.
  - offset 0x2 is control: bit 0 starts a transaction and reads back as the start/active flag; bit 4 clears the pointer when written as 1 and reads as 0.
  - offset 0x3 is status, with bit 7 as busy.
  - offset 0xC is the data port.
  - offset 0xD returns the pointer in bits 2:0.
  - Unmapped offsets read 0.
- R3: Each data-port access (read or accepted write) advances the pointer by one, modulo 8. Writing control with bit 4 set returns the pointer to 0.
- R4: A transaction holds `spi_cs_n` low and sends the opcode first, then store entries 0 up to transmit count minus 1. Bytes go MSB first in SPI mode 0: SCLK idles low, MOSI is set up before each rising edge, and MISO is sampled on the rising edge. Each SCLK phase lasts HALF_DIV clocks.
- R5: A transmit count above 8 is treated as 8.
- R6: Received byte i (counting from 0) is stored at entry (transmit count + i) mod 8. Payload entries not overwritten keep their values.
- R7: When the transmit count is 0, the number of bytes received is the receive field minus 1, or none if the field is 0.
- R8: Status bit 7 and control bit 0 read 1 from the cycle after the start write until the cycle in which `spi_cs_n` returns high, and read 0 in that cycle.
- R9: While busy, writes to the opcode, count, data port and start bit are ignored. An ignored data write does not move the pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| acc_valid | input | 1 | Register access request |
| acc_ready | output | 1 | Access accepted (always 1) |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_addr | input | 4 | Register offset |
| acc_wdata | input | 8 | Write data |
| acc_rdata | output | 8 | Read data for `acc_addr` (combinational) |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_sclk | output | 1 | Serial clock, mode 0 |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |

## Verification
The bench pairs a flash model with a response stream that is distinct for every byte position. This exposes response data written at the wrong store index, or an engine that clocks one byte too many or too few when nothing is transmitted; the wire byte count and an untouched neighbouring entry both show that error. Receive indices that run past entry 7 must wrap to entry 0, or the first payload bytes would survive where responses belong. Writes issued mid-transfer must leave the opcode, the count and the pointer intact. The busy flag is compared with chip select on every cycle, so a flag that drops a cycle early or late is caught.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;
  localparam logic [3:0] OFS_OPCODE = 4'h0;
  localparam logic [3:0] OFS_COUNT  = 4'h1;
  localparam logic [3:0] OFS_CTRL   = 4'h2;
  localparam logic [3:0] OFS_STATUS = 4'h3;
  localparam logic [3:0] OFS_DATA   = 4'hC;
  localparam logic [3:0] OFS_PTR    = 4'hD;

  localparam int CTRL_GO_BIT   = 0;
  localparam int CTRL_CLR_BIT  = 4;
  localparam int STAT_BUSY_BIT = 7;

  typedef enum logic [1:0] {
    SQ_IDLE  = 2'd0,
    SQ_ISSUE = 2'd1,
    SQ_WAIT  = 2'd2
  } seq_state_e;
endpackage

// File: rtl/spi_cmd_store.sv
module spi_cmd_store #(
  parameter int DEPTH = 8,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sw_acc,
  input  logic             sw_wr,
  input  logic [7:0]       sw_wdata,
  input  logic             sw_clr,
  output logic [7:0]       sw_rdata,
  output logic [PTR_W-1:0] ptr,
  input  logic [PTR_W-1:0] eng_ridx,
  output logic [7:0]       eng_rdata,
  input  logic             eng_we,
  input  logic [PTR_W-1:0] eng_widx,
  input  logic [7:0]       eng_wdata
);
  logic [7:0] mem [DEPTH];

  assign sw_rdata  = mem[ptr];
  assign eng_rdata = mem[eng_ridx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr <= '0;
    end else if (sw_clr) begin
      ptr <= '0;
    end else if (sw_acc) begin
      ptr <= ptr + 1'b1;
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_entry
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mem[g] <= 8'h00;
      end else if (eng_we && eng_widx == PTR_W'(g)) begin
        mem[g] <= eng_wdata;
      end else if (sw_acc && sw_wr && ptr == PTR_W'(g)) begin
        mem[g] <= sw_wdata;
      end
    end
  end

  // R3
  ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_acc && !sw_clr) |=> ptr == $past(ptr) + 1'b1);

  // R3
  ptr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sw_clr |=> ptr == '0);
endmodule

// File: rtl/spi_cmd_shifter.sv
module spi_cmd_shifter #(
  parameter int HALF_DIV = 2,
  localparam int DIV_W = $clog2(HALF_DIV) + 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tx_valid,
  output logic       tx_ready,
  input  logic [7:0] tx_byte,
  output logic       rx_valid,
  output logic [7:0] rx_byte,
  output logic       sclk,
  output logic       mosi,
  input  logic       miso
);
  logic             active;
  logic [DIV_W-1:0] div_q;
  logic [2:0]       bit_q;
  logic [7:0]       tx_sh;
  logic [7:0]       rx_sh;
  logic             tick;

  assign tx_ready = !active;
  assign tick     = (div_q == DIV_W'(HALF_DIV - 1));
  assign mosi     = active ? tx_sh[7] : 1'b0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active   <= 1'b0;
      div_q    <= '0;
      bit_q    <= '0;
      tx_sh    <= '0;
      rx_sh    <= '0;
      sclk     <= 1'b0;
      rx_valid <= 1'b0;
      rx_byte  <= '0;
    end else begin
      rx_valid <= 1'b0;
      if (!active) begin
        if (tx_valid) begin
          active <= 1'b1;
          tx_sh  <= tx_byte;
          div_q  <= '0;
          bit_q  <= '0;
          sclk   <= 1'b0;
        end
      end else if (!tick) begin
        div_q <= div_q + 1'b1;
      end else begin
        div_q <= '0;
        if (!sclk) begin
          sclk  <= 1'b1;
          rx_sh <= {rx_sh[6:0], miso};
        end else begin
          sclk <= 1'b0;
          if (bit_q == 3'd7) begin
            active   <= 1'b0;
            rx_valid <= 1'b1;
            rx_byte  <= rx_sh;
          end else begin
            bit_q <= bit_q + 1'b1;
            tx_sh <= {tx_sh[6:0], 1'b0};
          end
        end
      end
    end
  end

  // R4
  sclk_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> !sclk);

  // R4
  mosi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && sclk) |-> $stable(mosi));
endmodule

// File: rtl/spi_cmd_seq.sv
module spi_cmd_seq
  import spi_cmd_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int CNT_W = 4,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int TOT_W = CNT_W + 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [7:0]       opcode,
  input  logic [CNT_W-1:0] tx_cnt,
  input  logic [CNT_W-1:0] rx_cnt,
  output logic             busy,
  output logic             tx_valid,
  input  logic             tx_ready,
  output logic [7:0]       tx_byte,
  input  logic             rx_valid,
  input  logic [7:0]       rx_byte,
  output logic [PTR_W-1:0] f_ridx,
  input  logic [7:0]       f_rdata,
  output logic             f_we,
  output logic [PTR_W-1:0] f_widx,
  output logic [7:0]       f_wdata
);
  seq_state_e       state;
  logic [TOT_W-1:0] k_q;
  logic [TOT_W-1:0] last_k;
  logic [TOT_W-1:0] k_m1;
  logic             in_rx;

  assign last_k = TOT_W'(tx_cnt) + TOT_W'(rx_cnt);
  assign k_m1   = k_q - 1'b1;
  assign in_rx  = (k_q > TOT_W'(tx_cnt));

  assign tx_valid = (state == SQ_ISSUE);
  assign f_ridx   = k_m1[PTR_W-1:0];
  assign f_widx   = k_m1[PTR_W-1:0];
  assign f_wdata  = rx_byte;
  assign f_we     = (state == SQ_WAIT) && rx_valid && in_rx;

  always_comb begin
    if (k_q == '0) begin
      tx_byte = opcode;
    end else if (!in_rx) begin
      tx_byte = f_rdata;
    end else begin
      tx_byte = 8'h00;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= SQ_IDLE;
      k_q   <= '0;
      busy  <= 1'b0;
    end else begin
      case (state)
        SQ_IDLE: begin
          if (start) begin
            busy  <= 1'b1;
            k_q   <= '0;
            state <= SQ_ISSUE;
          end
        end
        SQ_ISSUE: begin
          if (tx_ready) begin
            state <= SQ_WAIT;
          end
        end
        SQ_WAIT: begin
          if (rx_valid) begin
            if (k_q == last_k) begin
              busy  <= 1'b0;
              state <= SQ_IDLE;
            end else begin
              k_q   <= k_q + 1'b1;
              state <= SQ_ISSUE;
            end
          end
        end
        default: state <= SQ_IDLE;
      endcase
    end
  end

  // R8
  no_issue_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !tx_valid);

  // R6
  store_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    f_we |-> busy);
endmodule

// File: rtl/spi_cmd_engine.sv
module spi_cmd_engine
  import spi_cmd_pkg::*;
#(
  parameter int DEPTH    = 8,
  parameter int CNT_W    = 4,
  parameter int HALF_DIV = 2,
  localparam int PTR_W   = $clog2(DEPTH)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       acc_valid,
  output logic       acc_ready,
  input  logic       acc_write,
  input  logic [3:0] acc_addr,
  input  logic [7:0] acc_wdata,
  output logic [7:0] acc_rdata,
  output logic       spi_cs_n,
  output logic       spi_sclk,
  output logic       spi_mosi,
  input  logic       spi_miso
);
  logic [7:0]       opcode_q;
  logic [7:0]       count_q;
  logic             busy;
  logic             wr;
  logic             start;
  logic             clr;
  logic             data_acc;
  logic [CNT_W-1:0] tx_field;
  logic [CNT_W-1:0] rx_field;
  logic [CNT_W-1:0] tx_eff;
  logic [CNT_W-1:0] rx_eff;
  logic [7:0]       sw_rdata;
  logic [PTR_W-1:0] ptr;
  logic [PTR_W-1:0] f_ridx;
  logic [7:0]       f_rdata;
  logic             f_we;
  logic [PTR_W-1:0] f_widx;
  logic [7:0]       f_wdata;
  logic             sh_tx_valid;
  logic             sh_tx_ready;
  logic [7:0]       sh_tx_byte;
  logic             sh_rx_valid;
  logic [7:0]       sh_rx_byte;

  assign acc_ready = 1'b1;
  assign wr        = acc_valid && acc_write;
  assign start     = wr && !busy && acc_addr == OFS_CTRL && acc_wdata[CTRL_GO_BIT];
  assign clr       = wr && acc_addr == OFS_CTRL && acc_wdata[CTRL_CLR_BIT];
  assign data_acc  = acc_valid && acc_addr == OFS_DATA && !(acc_write && busy);
  assign spi_cs_n  = !busy;

  assign tx_field = count_q[CNT_W-1:0];
  assign rx_field = count_q[2*CNT_W-1:CNT_W];
  assign tx_eff   = (tx_field > CNT_W'(DEPTH)) ? CNT_W'(DEPTH) : tx_field;
  assign rx_eff   = (tx_field != '0) ? rx_field :
                    (rx_field == '0) ? '0 : rx_field - 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      opcode_q <= '0;
      count_q  <= '0;
    end else if (wr && !busy) begin
      if (acc_addr == OFS_OPCODE) opcode_q <= acc_wdata;
      if (acc_addr == OFS_COUNT)  count_q  <= acc_wdata;
    end
  end

  always_comb begin
    acc_rdata = 8'h00;
    case (acc_addr)
      OFS_OPCODE: acc_rdata = opcode_q;
      OFS_COUNT:  acc_rdata = count_q;
      OFS_CTRL:   acc_rdata[CTRL_GO_BIT] = busy;
      OFS_STATUS: acc_rdata[STAT_BUSY_BIT] = busy;
      OFS_DATA:   acc_rdata = sw_rdata;
      OFS_PTR:    acc_rdata[PTR_W-1:0] = ptr;
      default:    acc_rdata = 8'h00;
    endcase
  end

  spi_cmd_store #(.DEPTH(DEPTH)) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .sw_acc    (data_acc),
    .sw_wr     (acc_write),
    .sw_wdata  (acc_wdata),
    .sw_clr    (clr),
    .sw_rdata  (sw_rdata),
    .ptr       (ptr),
    .eng_ridx  (f_ridx),
    .eng_rdata (f_rdata),
    .eng_we    (f_we),
    .eng_widx  (f_widx),
    .eng_wdata (f_wdata)
  );

  spi_cmd_seq #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .opcode   (opcode_q),
    .tx_cnt   (tx_eff),
    .rx_cnt   (rx_eff),
    .busy     (busy),
    .tx_valid (sh_tx_valid),
    .tx_ready (sh_tx_ready),
    .tx_byte  (sh_tx_byte),
    .rx_valid (sh_rx_valid),
    .rx_byte  (sh_rx_byte),
    .f_ridx   (f_ridx),
    .f_rdata  (f_rdata),
    .f_we     (f_we),
    .f_widx   (f_widx),
    .f_wdata  (f_wdata)
  );

  spi_cmd_shifter #(.HALF_DIV(HALF_DIV)) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .tx_valid (sh_tx_valid),
    .tx_ready (sh_tx_ready),
    .tx_byte  (sh_tx_byte),
    .rx_valid (sh_rx_valid),
    .rx_byte  (sh_rx_byte),
    .sclk     (spi_sclk),
    .mosi     (spi_mosi),
    .miso     (spi_miso)
  );

  // R9
  opcode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && wr && acc_addr == OFS_OPCODE) |=> opcode_q == $past(opcode_q));

  // R9
  count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(count_q));

  // R4
  cs_edge_sclk_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(spi_cs_n) |-> !spi_sclk);
endmodule

// File: tb/test_spi_cmd_engine.sv
module test_spi_cmd_engine;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       acc_valid = 1'b0;
  logic       acc_ready;
  logic       acc_write = 1'b0;
  logic [3:0] acc_addr = 4'h0;
  logic [7:0] acc_wdata = 8'h00;
  logic [7:0] acc_rdata;
  logic       spi_cs_n, spi_sclk, spi_mosi, spi_miso;

  int n_checks = 0;
  int n_fail   = 0;
  int cyc      = 0;
  bit done     = 0;

  int         mo_bits = 0;
  int         mi_bits = 0;
  int         cap_n   = 0;
  logic [7:0] mo_sh   = 8'h00;
  logic [7:0] cap [0:31];

  always #5 clk = ~clk;

  spi_cmd_engine i_spi_cmd_engine (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_ready(acc_ready),
    .acc_write(acc_write), .acc_addr(acc_addr), .acc_wdata(acc_wdata),
    .acc_rdata(acc_rdata), .spi_cs_n(spi_cs_n), .spi_sclk(spi_sclk),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso)
  );

  function automatic logic [7:0] resp(int n);
    return 8'h90 + n[7:0];
  endfunction

  assign spi_miso = resp(mi_bits / 8)[7 - (mi_bits % 8)];

  always @(posedge spi_sclk) begin
    if (!spi_cs_n) begin
      mo_sh = {mo_sh[6:0], spi_mosi};
      mo_bits = mo_bits + 1;
      if (mo_bits % 8 == 0) begin
        if (cap_n < 32) cap[cap_n] = mo_sh;
        cap_n = cap_n + 1;
      end
    end
  end

  always @(negedge spi_sclk) begin
    if (!spi_cs_n) mi_bits = mi_bits + 1;
  end

  task automatic check(bit ok, string req, int act, int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected <150000 cycles", cyc);
      summary();
    end
  end

  task automatic wr_reg(logic [3:0] a, logic [7:0] d);
    @(negedge clk);
    acc_valid = 1'b1; acc_write = 1'b1; acc_addr = a; acc_wdata = d;
    @(negedge clk);
    acc_valid = 1'b0; acc_write = 1'b0;
  endtask

  task automatic rd_reg(logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    acc_valid = 1'b1; acc_write = 1'b0; acc_addr = a;
    #1 d = acc_rdata;
    @(negedge clk);
    acc_valid = 1'b0;
  endtask

  task automatic start_exec();
    mo_bits = 0; mi_bits = 0; cap_n = 0;
    wr_reg(4'h2, 8'h01);
  endtask

  task automatic wait_done();
    int mism = 0;
    int guard = 0;
    acc_addr = 4'h3;
    #1;
    while (!spi_cs_n && guard < 5000) begin
      if (acc_rdata[7] !== 1'b1) mism++;
      @(negedge clk); #1;
      guard++;
    end
    // R8: busy bit is 0 in the cycle cs_n returns high
    if (acc_rdata[7] !== 1'b0) mism++;
    check(mism == 0 && guard < 5000, "R8 busy tracks cs", mism, 0);
  endtask

  task automatic load_fifo(logic [7:0] base);
    wr_reg(4'h2, 8'h10);
    for (int i = 0; i < 8; i++) wr_reg(4'hC, base + 8'(i));
  endtask

  task automatic t_reset();
    logic [7:0] d;
    check(spi_cs_n === 1'b1, "R1 cs_n", spi_cs_n, 1);
    check(spi_sclk === 1'b0, "R1 sclk", spi_sclk, 0);
    check(acc_ready === 1'b1, "R1 ready", acc_ready, 1);
    foreach (d[i]) ;
    begin
      logic [3:0] offs [6] = '{4'h0, 4'h1, 4'h2, 4'h3, 4'hD, 4'hC};
      for (int i = 0; i < 6; i++) begin
        rd_reg(offs[i], d);
        check(d === 8'h00, "R1 reg zero", d, 0);
      end
    end
  endtask

  task automatic t_basic();
    logic [7:0] d;
    wr_reg(4'h0, 8'h0B);
    wr_reg(4'h1, 8'h23);
    rd_reg(4'h1, d);
    check(d === 8'h23, "R2 count readback", d, 8'h23);
    wr_reg(4'h2, 8'h10);
    wr_reg(4'hC, 8'hA1); wr_reg(4'hC, 8'hA2); wr_reg(4'hC, 8'hA3);
    rd_reg(4'hD, d);
    check(d === 8'h03, "R3 ptr after 3 writes", d, 3);
    start_exec();
    wait_done();
    check(cap_n == 6, "R4 byte count tx3 rx2", cap_n, 6);
    check(cap[0] === 8'h0B, "R4 opcode first", cap[0], 8'h0B);
    check(cap[1] === 8'hA1 && cap[2] === 8'hA2 && cap[3] === 8'hA3,
          "R4 payload order", cap[3], 8'hA3);
    wr_reg(4'h2, 8'h10);
    rd_reg(4'hC, d); check(d === 8'hA1, "R6 payload kept 0", d, 8'hA1);
    rd_reg(4'hC, d); rd_reg(4'hC, d);
    check(d === 8'hA3, "R6 payload kept 2", d, 8'hA3);
    rd_reg(4'hC, d); check(d === resp(4), "R6 rx byte 0", d, resp(4));
    rd_reg(4'hC, d); check(d === resp(5), "R6 rx byte 1", d, resp(5));
  endtask

  task automatic t_no_tx();
    logic [7:0] d;
    load_fifo(8'h20);
    wr_reg(4'h1, 8'h30);
    start_exec();
    wait_done();
    check(cap_n == 3, "R7 tx0 rx field3 wire bytes", cap_n, 3);
    wr_reg(4'h2, 8'h10);
    rd_reg(4'hC, d); check(d === resp(1), "R7 rx0 at entry0", d, resp(1));
    rd_reg(4'hC, d); check(d === resp(2), "R7 rx1 at entry1", d, resp(2));
    rd_reg(4'hC, d); check(d === 8'h22, "R7 entry2 untouched", d, 8'h22);
  endtask

  task automatic t_wrap_rx();
    logic [7:0] d;
    logic [7:0] exp [8];
    load_fifo(8'h40);
    wr_reg(4'h1, 8'h46);
    start_exec();
    wait_done();
    check(cap_n == 11, "R6 tx6 rx4 wire bytes", cap_n, 11);
    for (int i = 0; i < 8; i++) exp[i] = 8'h40 + 8'(i);
    exp[6] = resp(7); exp[7] = resp(8); exp[0] = resp(9); exp[1] = resp(10);
    wr_reg(4'h2, 8'h10);
    for (int i = 0; i < 8; i++) begin
      rd_reg(4'hC, d);
      check(d === exp[i], "R6 wrapped store", d, exp[i]);
    end
    rd_reg(4'hD, d);
    check(d === 8'h00, "R3 ptr wraps after 8 reads", d, 0);
  endtask

  task automatic t_clamp();
    logic [7:0] d;
    load_fifo(8'h60);
    wr_reg(4'h1, 8'h0C);
    start_exec();
    wait_done();
    check(cap_n == 9, "R5 tx12 clamped to 8", cap_n, 9);
    check(cap[8] === 8'h67, "R5 last payload", cap[8], 8'h67);
    wr_reg(4'h2, 8'h10);
    rd_reg(4'hC, d);
    check(d === 8'h60, "R5 store unchanged", d, 8'h60);
  endtask

  task automatic t_busy_ignore();
    logic [7:0] d;
    logic [7:0] p0;
    wr_reg(4'h0, 8'h9F);
    wr_reg(4'h1, 8'h31);
    wr_reg(4'h2, 8'h10);
    wr_reg(4'hC, 8'h55);
    rd_reg(4'hD, p0);
    start_exec();
    rd_reg(4'h2, d);
    check(d[0] === 1'b1, "R8 start bit reads 1", d[0], 1);
    wr_reg(4'h0, 8'hEE);
    wr_reg(4'h1, 8'hFF);
    wr_reg(4'hC, 8'h77);
    wr_reg(4'h2, 8'h01);
    rd_reg(4'hD, d);
    check(d === p0, "R9 ptr unmoved by busy write", d, p0);
    wait_done();
    rd_reg(4'h2, d);
    check(d[0] === 1'b0, "R8 start bit clears", d[0], 0);
    check(cap_n == 5, "R9 count write ignored", cap_n, 5);
    rd_reg(4'h0, d);
    check(d === 8'h9F, "R9 opcode write ignored", d, 8'h9F);
    rd_reg(4'h1, d);
    check(d === 8'h31, "R9 count reg kept", d, 8'h31);
    repeat (20) @(negedge clk);
    check(spi_cs_n === 1'b1, "R9 start while busy no rerun", spi_cs_n, 1);
    wr_reg(4'h2, 8'h10);
    rd_reg(4'hC, d);
    check(d === 8'h55, "R9 data write ignored", d, 8'h55);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_no_tx();
    t_wrap_rx();
    t_clamp();
    t_busy_ignore();
    done = 1;
    summary();
  end
endmodule